// File: doc/BRIEF.md
# Non-volatile image loader with checksum

This block keeps a 256-entry volatile register image in step with a 256-byte non-volatile store. Software talks to it through a 16-bit command word: one command copies the whole store into the image, another forces the same upload on demand, and a single-byte command either fetches one byte from the store into the image or pushes one image byte back into the store. Each time reset is released, the block runs a full upload on its own, so the image always starts from the stored contents.

The store is modelled as a plain synchronous port. The block holds a request until the store answers with an acknowledge; an error flag may come back with that acknowledge. Every full sweep that finishes without a store error produces an 8-bit checksum: the low byte of the sum of image bytes 0 through 117. That checksum is compared with byte 118. The block publishes the computed checksum, a match flag and a two-bit status code.

Ordinary host writes touch only the image. Nothing reaches the store except through the single-byte write command.

Top module: `nvr_image_ctrl`

## Requirements
- R1: While rst_n is low: status is 0, busy is 0, csum_value is 0, csum_match is 0, nv_req is 0 and every image entry reads 0. On the first clock edge after rst_n rises, the block becomes busy (status 1).
- R2: The full upload that starts after reset copies every store byte into the image and ends with status 2.
- R3: A command with cmd_word[1:0]=00 and cmd_word[5]=0 reloads all 256 image entries from the store, in ascending address order.
- R4: After an error-free full sweep, csum_value is the low 8 bits of the sum of bytes 0..117, and csum_match is 1 exactly when that value equals byte 118.
- R5: A command with cmd_word[1:0]=10 and cmd_word[5]=0 copies store byte cmd_word[15:8] into that image entry. Other entries and the checksum outputs are left unchanged.
- R6: A command with cmd_word[1:0]=10 and cmd_word[5]=1 writes image entry cmd_word[15:8] into the store at that address. The image is left unchanged. nv_we is high only during this command.
- R7: A command with cmd_word[1:0]=11 and cmd_word[5]=0 performs the same full upload and checksum as R3.
- R8: A host write (reg_we) changes only the addressed image entry. It raises no store request.
- R9: A command strobed while busy is ignored.
- R10: Commands are ignored, with status and contents unchanged, in these cases: code 01; code 00 or 11 with bit 5 set; or any reserved bit (cmd_word[7:6], cmd_word[4:2]) set.
- R11: If any store access in an operation returns nv_err, the operation ends with status 3. csum_value and csum_match keep their previous values, and the failing byte is not written into the image.
- R12: Status codes are 0 idle, 1 busy, 2 complete, 3 failed. busy is high exactly when the status is 1.
- R13: While nv_req is high and not yet acknowledged, nv_req, nv_addr and nv_we hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release starts an upload |
| reg_we | input | 1 | Host write strobe for the image |
| reg_addr | input | AW | Host image address (read and write) |
| reg_wdata | input | DW | Host write data |
| reg_rdata | output | DW | Image entry at reg_addr |
| cmd_wr | input | 1 | Command strobe |
| cmd_word | input | 16 | Command: [15:8] byte address, [5] write select, [1:0] command code |
| nv_req | output | 1 | Store access request |
| nv_we | output | 1 | Store access is a write |
| nv_addr | output | AW | Store byte address |
| nv_wdata | output | DW | Store write data |
| nv_rdata | input | DW | Store read data, valid with nv_ack |
| nv_ack | input | 1 | Store access complete |
| nv_err | input | 1 | Store access failed, valid with nv_ack |
| busy | output | 1 | Operation in progress |
| status | output | 2 | 0 idle, 1 busy, 2 complete, 3 failed |
| csum_value | output | DW | Last computed checksum |
| csum_match | output | 1 | Last computed checksum equals byte 118 |

## Verification
On every cycle, the embedded properties check three things: that a store request holds until it is acknowledged, that no request appears outside an operation, and that writes go to the store only during the single-byte write command. They also check that the checksum outputs move only when a clean full sweep ends, that the match flag tracks the captured reference byte, and that host writes land in the image. Only the directed scenarios can show the rest. These cover: the image contents after each kind of transfer; the exact checksum value over a known pattern; commands dropped while busy or because of their encoding; and the failed status with preserved checksum after an injected store error.

// File: rtl/nvr_pkg.sv
package nvr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUSY = 2'd1,
      ST_DONE = 2'd2,
      ST_FAIL = 2'd3
   } nvr_stat_e;

   typedef enum logic [1:0] {
      OP_FULL = 2'd0,
      OP_SRD  = 2'd1,
      OP_SWR  = 2'd2
   } nvr_op_e;

   localparam logic [1:0] EXT_FULL   = 2'b00;
   localparam logic [1:0] EXT_SINGLE = 2'b10;
   localparam logic [1:0] EXT_UPLOAD = 2'b11;
   localparam int         RW_BIT     = 5;
   localparam int         ADDR_LSB   = 8;

endpackage

// File: rtl/nvr_cmd_decode.sv
module nvr_cmd_decode
   import nvr_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          cmd_wr,
   input  logic [15:0]   cmd_word,
   output logic          cmd_go,
   output nvr_op_e       cmd_op,
   output logic [AW-1:0] cmd_addr
);

   logic [1:0] ext;
   logic       rw;
   logic       rsvd_set;
   logic       valid;

   assign ext      = cmd_word[1:0];
   assign rw       = cmd_word[RW_BIT];
   assign rsvd_set = |{cmd_word[7:6], cmd_word[4:2]};
   assign cmd_addr = cmd_word[ADDR_LSB +: AW];

   always_comb begin
      valid  = 1'b0;
      cmd_op = OP_FULL;
      unique case (ext)
         EXT_FULL, EXT_UPLOAD: begin
            valid  = !rw;
            cmd_op = OP_FULL;
         end
         EXT_SINGLE: begin
            valid  = 1'b1;
            cmd_op = rw ? OP_SWR : OP_SRD;
         end
         default: valid = 1'b0;
      endcase
   end

   assign cmd_go = cmd_wr && valid && !rsvd_set;

endmodule

// File: rtl/nvr_image.sv
module nvr_image #(
   parameter int AW          = 8,
   parameter int DW          = 8,
   parameter bit RESET_IMAGE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          s_we,
   input  logic [AW-1:0] s_addr,
   input  logic [DW-1:0] s_wdata,
   output logic [DW-1:0] s_rdata,
   input  logic          h_we,
   input  logic [AW-1:0] h_addr,
   input  logic [DW-1:0] h_wdata,
   output logic [DW-1:0] h_rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];
   logic          h_take;

   // A sequencer write to the same entry wins over the host.
   assign h_take  = h_we && !(s_we && (s_addr == h_addr));
   assign s_rdata = mem[s_addr];
   assign h_rdata = mem[h_addr];

   generate
      if (RESET_IMAGE) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else begin
               if (s_we)   mem[s_addr] <= s_wdata;
               if (h_take) mem[h_addr] <= h_wdata;
            end
         end
      end else begin : g_nrst
         always_ff @(posedge clk) begin
            if (s_we)   mem[s_addr] <= s_wdata;
            if (h_take) mem[h_addr] <= h_wdata;
         end
      end
   endgenerate

   // R8
   host_wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (h_we && !s_we) |=> (mem[$past(h_addr)] == $past(h_wdata)));

endmodule

// File: rtl/nvr_checksum.sv
module nvr_checksum #(
   parameter int AW        = 8,
   parameter int DW        = 8,
   parameter int CSUM_LAST = 117,
   parameter int CSUM_IDX  = 118
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_clr,
   input  logic          byte_vld,
   input  logic [AW-1:0] byte_addr,
   input  logic [DW-1:0] byte_data,
   input  logic          fin_ok,
   output logic [DW-1:0] csum_value,
   output logic          csum_match
);

   localparam logic [AW-1:0] LAST_A = AW'(CSUM_LAST);
   localparam logic [AW-1:0] REF_A  = AW'(CSUM_IDX);

   logic [DW-1:0] acc;
   logic [DW-1:0] ref_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc   <= '0;
         ref_q <= '0;
      end else if (run_clr) begin
         acc   <= '0;
         ref_q <= '0;
      end else if (byte_vld) begin
         if (byte_addr <= LAST_A) acc   <= acc + byte_data;
         if (byte_addr == REF_A)  ref_q <= byte_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csum_value <= '0;
         csum_match <= 1'b0;
      end else if (fin_ok) begin
         csum_value <= acc;
         csum_match <= (acc == ref_q);
      end
   end

   // R11
   csum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fin_ok |=> ($stable(csum_value) && $stable(csum_match)));

   // R4
   csum_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin_ok |=> (csum_match == (csum_value == $past(ref_q))));

endmodule

// File: rtl/nvr_seq.sv
module nvr_seq
   import nvr_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_go,
   input  nvr_op_e       cmd_op,
   input  logic [AW-1:0] cmd_addr,
   output logic          nv_req,
   output logic          nv_we,
   output logic [AW-1:0] nv_addr,
   output logic [DW-1:0] nv_wdata,
   input  logic [DW-1:0] nv_rdata,
   input  logic          nv_ack,
   input  logic          nv_err,
   input  logic [DW-1:0] img_rdata,
   output logic          img_we,
   output logic [AW-1:0] img_addr,
   output logic [DW-1:0] img_wdata,
   output logic          run_clr,
   output logic          byte_vld,
   output logic          fin_ok,
   output nvr_stat_e     stat
);

   logic          xfer;
   nvr_op_e       op_q;
   logic [AW-1:0] addr_q;
   logic          err_q;
   logic          auto_pend;
   logic          start;
   logic          last;
   logic          acked;

   assign start     = !xfer && (auto_pend || cmd_go);
   assign last      = (op_q != OP_FULL) || (addr_q == '1);
   assign acked     = xfer && nv_ack;

   assign nv_req    = xfer;
   assign nv_we     = xfer && (op_q == OP_SWR);
   assign nv_addr   = addr_q;
   assign nv_wdata  = img_rdata;

   assign img_addr  = addr_q;
   assign img_wdata = nv_rdata;
   assign img_we    = acked && !nv_err && (op_q != OP_SWR);

   assign run_clr   = start;
   assign byte_vld  = img_we && (op_q == OP_FULL);
   assign fin_ok    = acked && last && (op_q == OP_FULL) && !err_q && !nv_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xfer      <= 1'b0;
         op_q      <= OP_FULL;
         addr_q    <= '0;
         err_q     <= 1'b0;
         auto_pend <= 1'b1;
         stat      <= ST_IDLE;
      end else if (start) begin
         xfer      <= 1'b1;
         op_q      <= auto_pend ? OP_FULL : cmd_op;
         addr_q    <= (auto_pend || cmd_op == OP_FULL) ? '0 : cmd_addr;
         err_q     <= 1'b0;
         auto_pend <= 1'b0;
         stat      <= ST_BUSY;
      end else if (acked) begin
         if (nv_err) err_q <= 1'b1;
         if (last) begin
            xfer <= 1'b0;
            stat <= (err_q || nv_err) ? ST_FAIL : ST_DONE;
         end else begin
            addr_q <= addr_q + 1'b1;
         end
      end
   end

   // R13
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_req && !nv_ack) |=> (nv_req && $stable(nv_addr) && $stable(nv_we)));

   // R8
   idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat != ST_BUSY) |-> !nv_req);

   // R6
   we_only_swr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nv_we |-> (nv_req && op_q == OP_SWR));

   // R9
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && cmd_go && !nv_ack) |=> ($stable(op_q) && $stable(addr_q) && xfer));

endmodule

// File: rtl/nvr_image_ctrl.sv
module nvr_image_ctrl
   import nvr_pkg::*;
#(
   parameter int AW          = 8,
   parameter int DW          = 8,
   parameter int CSUM_LAST   = 117,
   parameter int CSUM_IDX    = 118,
   parameter bit RESET_IMAGE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [AW-1:0] reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          cmd_wr,
   input  logic [15:0]   cmd_word,
   output logic          nv_req,
   output logic          nv_we,
   output logic [AW-1:0] nv_addr,
   output logic [DW-1:0] nv_wdata,
   input  logic [DW-1:0] nv_rdata,
   input  logic          nv_ack,
   input  logic          nv_err,
   output logic          busy,
   output logic [1:0]    status,
   output logic [DW-1:0] csum_value,
   output logic          csum_match
);

   localparam int DEPTH = 1 << AW;

   generate
      if (AW > 8 || AW < 1) begin : g_bad_aw
         $error("AW must lie in 1..8 to fit the command address field");
      end
      if (CSUM_IDX >= DEPTH - 1) begin : g_bad_idx
         $error("CSUM_IDX must be below the last image address");
      end
      if (CSUM_LAST >= CSUM_IDX) begin : g_bad_last
         $error("CSUM_LAST must be below CSUM_IDX");
      end
   endgenerate

   logic          cmd_go;
   nvr_op_e       cmd_op;
   logic [AW-1:0] cmd_addr;
   logic          img_we;
   logic [AW-1:0] img_addr;
   logic [DW-1:0] img_wdata;
   logic [DW-1:0] img_rdata;
   logic          run_clr;
   logic          byte_vld;
   logic          fin_ok;
   nvr_stat_e     stat;

   nvr_cmd_decode #(.AW(AW)) u_dec (
      .cmd_wr   (cmd_wr),
      .cmd_word (cmd_word),
      .cmd_go   (cmd_go),
      .cmd_op   (cmd_op),
      .cmd_addr (cmd_addr)
   );

   nvr_seq #(.AW(AW), .DW(DW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_go    (cmd_go),
      .cmd_op    (cmd_op),
      .cmd_addr  (cmd_addr),
      .nv_req    (nv_req),
      .nv_we     (nv_we),
      .nv_addr   (nv_addr),
      .nv_wdata  (nv_wdata),
      .nv_rdata  (nv_rdata),
      .nv_ack    (nv_ack),
      .nv_err    (nv_err),
      .img_rdata (img_rdata),
      .img_we    (img_we),
      .img_addr  (img_addr),
      .img_wdata (img_wdata),
      .run_clr   (run_clr),
      .byte_vld  (byte_vld),
      .fin_ok    (fin_ok),
      .stat      (stat)
   );

   nvr_image #(.AW(AW), .DW(DW), .RESET_IMAGE(RESET_IMAGE)) u_img (
      .clk     (clk),
      .rst_n   (rst_n),
      .s_we    (img_we),
      .s_addr  (img_addr),
      .s_wdata (img_wdata),
      .s_rdata (img_rdata),
      .h_we    (reg_we),
      .h_addr  (reg_addr),
      .h_wdata (reg_wdata),
      .h_rdata (reg_rdata)
   );

   nvr_checksum #(.AW(AW), .DW(DW), .CSUM_LAST(CSUM_LAST), .CSUM_IDX(CSUM_IDX)) u_sum (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_clr    (run_clr),
      .byte_vld   (byte_vld),
      .byte_addr  (img_addr),
      .byte_data  (img_wdata),
      .fin_ok     (fin_ok),
      .csum_value (csum_value),
      .csum_match (csum_match)
   );

   assign status = stat;
   assign busy   = (stat == ST_BUSY);

   // R12
   busy_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (status == 2'd1 && nv_req));

endmodule

// File: tb/nvr_image_ctrl_test.sv
`timescale 1ns/1ps
module nvr_image_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        cmd_wr = 1'b0;
   logic [15:0] cmd_word = '0;
   logic        nv_req, nv_we;
   logic [7:0]  nv_addr, nv_wdata;
   logic [7:0]  nv_rdata = '0;
   logic        nv_ack = 1'b0;
   logic        nv_err = 1'b0;
   logic        busy, csum_match;
   logic [1:0]  status;
   logic [7:0]  csum_value;

   logic [7:0]  store [256];
   logic        err_on = 1'b0;
   logic [7:0]  err_addr = '0;
   int          checks = 0;
   int          errors = 0;
   int          cyc = 0;
   logic [7:0]  exp_csum;
   logic        exp_ok;

   always #2 clk = ~clk;

   nvr_image_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_wr(cmd_wr),
      .cmd_word(cmd_word), .nv_req(nv_req), .nv_we(nv_we), .nv_addr(nv_addr),
      .nv_wdata(nv_wdata), .nv_rdata(nv_rdata), .nv_ack(nv_ack), .nv_err(nv_err),
      .busy(busy), .status(status), .csum_value(csum_value), .csum_match(csum_match)
   );

   // store model: acknowledges one cycle after a request is seen
   always @(posedge clk) begin
      if (nv_req && !nv_ack) begin
         nv_ack   <= 1'b1;
         nv_err   <= err_on && (nv_addr == err_addr);
         nv_rdata <= store[nv_addr];
         if (nv_we) store[nv_addr] <= nv_wdata;
      end else begin
         nv_ack <= 1'b0;
         nv_err <= 1'b0;
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         checks++; errors++;
         $display("FAIL R2 watchdog expired act=%0d exp=%0d", cyc, 100000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] sum_ref();
      logic [7:0] s = '0;
      for (int i = 0; i <= 117; i++) s = s + store[i];
      return s;
   endfunction

   function automatic logic [15:0] mk(input logic [7:0] a, input bit rw, input logic [1:0] ext);
      return {a, 2'b00, rw, 3'b000, ext};
   endfunction

   task automatic rd_img(input logic [7:0] a, output logic [7:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wr_img(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic do_cmd(input logic [15:0] w);
      @(negedge clk);
      cmd_wr = 1'b1; cmd_word = w;
      @(negedge clk);
      cmd_wr = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic cmp_image(input string req);
      logic [7:0] d;
      int bad = 0;
      int first = -1;
      for (int i = 0; i < 256; i++) begin
         rd_img(8'(i), d);
         if (d !== store[i]) begin
            bad++;
            if (first < 0) first = i;
         end
      end
      chk(bad == 0, req, first, -1);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      for (int i = 0; i < 256; i++) store[i] = 8'(i * 7 + 3);
      store[118] = sum_ref();
      repeat (3) @(negedge clk);
      chk(status == 2'd0, "R1 status in reset", status, 0);
      chk(busy == 1'b0 && nv_req == 1'b0, "R1 busy/req in reset", {busy, nv_req}, 0);
      chk(csum_value == 8'd0 && csum_match == 1'b0, "R1 checksum in reset", csum_value, 0);
      rd_img(8'd77, d);
      chk(d == 8'd0, "R1 image in reset", d, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b1 && status == 2'd1, "R1 busy after release", status, 1);
   endtask

   task automatic t_auto_upload();
      wait_idle();
      chk(status == 2'd2, "R12 complete code", status, 2);
      cmp_image("R2 image after auto upload");
      exp_csum = sum_ref(); exp_ok = 1'b1;
      chk(csum_value == exp_csum, "R4 checksum value", csum_value, exp_csum);
      chk(csum_match == 1'b1, "R4 checksum match", csum_match, 1);
   endtask

   task automatic t_host_write();
      logic [7:0] d;
      logic       saw_req = 1'b0;
      logic [7:0] old = store[5];
      wr_img(8'd5, 8'hAA);
      for (int i = 0; i < 4; i++) begin
         if (nv_req) saw_req = 1'b1;
         @(negedge clk);
      end
      rd_img(8'd5, d);
      chk(d == 8'hAA, "R8 host write lands", d, 8'hAA);
      chk(!saw_req && store[5] == old, "R8 store untouched", store[5], old);
   endtask

   task automatic t_single_write();
      logic [7:0] d;
      do_cmd(mk(8'd5, 1'b1, 2'b10));
      wait_idle();
      chk(store[5] == 8'hAA, "R6 single write to store", store[5], 8'hAA);
      rd_img(8'd5, d);
      chk(d == 8'hAA, "R6 image unchanged", d, 8'hAA);
      chk(status == 2'd2 && csum_value == exp_csum, "R6 status/checksum", csum_value, exp_csum);
   endtask

   task automatic t_single_read();
      logic [7:0] d;
      logic [7:0] old10;
      rd_img(8'd10, old10);
      store[9]  = 8'h3C;
      store[10] = 8'hE1;
      do_cmd(mk(8'd9, 1'b0, 2'b10));
      wait_idle();
      rd_img(8'd9, d);
      chk(d == 8'h3C, "R5 single read fetched", d, 8'h3C);
      rd_img(8'd10, d);
      chk(d == old10, "R5 neighbour untouched", d, old10);
      chk(csum_value == exp_csum && csum_match == exp_ok, "R5 checksum kept", csum_value, exp_csum);
   endtask

   task automatic t_full_mismatch();
      store[0]   = 8'h99;
      store[118] = sum_ref() ^ 8'h01;
      do_cmd(mk(8'd0, 1'b0, 2'b00));
      chk(busy == 1'b1, "R3 full read starts", busy, 1);
      wait_idle();
      cmp_image("R3 image after full read");
      exp_csum = sum_ref(); exp_ok = 1'b0;
      chk(csum_value == exp_csum, "R4 checksum value after reload", csum_value, exp_csum);
      chk(csum_match == 1'b0, "R4 mismatch flagged", csum_match, 0);
   endtask

   task automatic t_upload();
      store[118] = sum_ref();
      wr_img(8'd20, 8'h55);
      do_cmd(mk(8'd0, 1'b0, 2'b11));
      wait_idle();
      cmp_image("R7 image after forced upload");
      exp_csum = sum_ref(); exp_ok = 1'b1;
      chk(csum_match == 1'b1 && csum_value == exp_csum, "R7 checksum after upload", csum_value, exp_csum);
   endtask

   task automatic t_busy_ignore();
      logic [7:0] old = store[30];
      wr_img(8'd30, 8'hC3);
      do_cmd(mk(8'd0, 1'b0, 2'b00));
      do_cmd(mk(8'd30, 1'b1, 2'b10));
      wait_idle();
      chk(store[30] == old, "R9 busy command ignored", store[30], old);
      cmp_image("R9 full read unaffected");
   endtask

   task automatic t_invalid();
      logic [7:0] d;
      logic [15:0] bad [4];
      bad[0] = mk(8'd40, 1'b0, 2'b01);
      bad[1] = mk(8'd40, 1'b1, 2'b00);
      bad[2] = mk(8'd40, 1'b1, 2'b11);
      bad[3] = mk(8'd40, 1'b1, 2'b10) | 16'h0004;
      wr_img(8'd40, 8'h0F);
      for (int k = 0; k < 4; k++) begin
         do_cmd(bad[k]);
         chk(busy == 1'b0 && status == 2'd2, "R10 invalid command ignored", status, 2);
      end
      rd_img(8'd40, d);
      chk(d == 8'h0F && store[40] != 8'h0F, "R10 contents unchanged", d, 8'h0F);
   endtask

   task automatic t_error();
      logic [7:0] d;
      wr_img(8'd50, 8'h5A);
      err_on = 1'b1; err_addr = 8'd50;
      store[118] = store[118] ^ 8'hFF;
      do_cmd(mk(8'd0, 1'b0, 2'b00));
      wait_idle();
      err_on = 1'b0;
      chk(status == 2'd3, "R11 failed code", status, 3);
      chk(csum_value == exp_csum && csum_match == exp_ok, "R11 checksum kept", csum_value, exp_csum);
      rd_img(8'd50, d);
      chk(d == 8'h5A, "R11 failing byte not written", d, 8'h5A);
      do_cmd(mk(8'd0, 1'b0, 2'b00));
      wait_idle();
      chk(status == 2'd2 && csum_match == 1'b0, "R12 recovers to complete", status, 2);
   endtask

   task automatic t_soft_reset();
      logic [7:0] d;
      store[118] = sum_ref();
      wr_img(8'd3, 8'h00);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rd_img(8'd200, d);
      chk(status == 2'd0 && d == 8'd0 && csum_value == 8'd0, "R1 second reset", status, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b1, "R2 auto upload again", busy, 1);
      wait_idle();
      cmp_image("R2 image after second reset");
      chk(csum_match == 1'b1, "R2 checksum after second reset", csum_match, 1);
   endtask

   initial begin
      t_reset();
      t_auto_upload();
      t_host_write();
      t_single_write();
      t_single_read();
      t_full_mismatch();
      t_upload();
      t_busy_ignore();
      t_invalid();
      t_error();
      t_soft_reset();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule